// File: doc/BRIEF.md
# On-the-Fly Signed-Digit to Binary Converter

This block turns a stream of signed digits, each worth -1, 0 or +1 and delivered most significant first, into an ordinary two's complement number, one digit per clock. It is meant to sit beside an iterative root or quotient datapath. That datapath produces redundant digits and needs the conventional value of the digits produced so far, every cycle, as feedback.

Two registers are kept side by side. The first holds the converted prefix. The second holds that prefix minus one at the same weight. Each new digit builds both next values by shifting one of the two current values left and placing a fixed bit at the bottom. A carry chain is therefore never needed. When the iteration ends, the caller may signal that its final remainder came out negative. The result output then shows the decremented value instead of the plain one, at no extra cost.

Top module: `sdc_onthefly_conv`

## Requirements
- R1: A digit is carried on two wires, a plus wire and a minus wire, with value plus minus minus. Plus=1 with minus=0 means +1. Plus=0 with minus=1 means -1. Both low or both high means 0.
- R2: A digit is taken only in a cycle where both the digit-valid and the shift-enable inputs are high. In any other cycle without clear, both value outputs keep their value.
- R3: On the clock edge that takes a digit d, the value output becomes twice its old value plus d, reduced modulo 2^W. After a clear, it therefore equals the weighted signed sum of the digits taken, modulo 2^W.
- R4: Outside reset, the decremented output always equals the value output minus one, modulo 2^W.
- R5: A clear input sets the value output to zero and the decremented output to all ones on the next edge. A clear takes priority over a digit presented in the same cycle.
- R6: A synchronous, active-high reset gives the same state as a clear.
- R7: The result output is combinational. It shows the decremented output while the negative-remainder input is high, and the value output otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Start a new conversion |
| dig_vld_i | input | 1 | Digit wires carry a digit |
| shift_en_i | input | 1 | Allow the registers to advance |
| dig_pos_i | input | 1 | Plus wire of the digit |
| dig_neg_i | input | 1 | Minus wire of the digit |
| neg_rem_i | input | 1 | Final remainder was negative |
| q_o | output | W | Converted prefix |
| qm_o | output | W | Converted prefix minus one |
| root_o | output | W | Corrected result |

## Verification
Clear and digit acceptance can land on the same edge. The bench provokes this by asserting clear while presenting a valid, enabled, nonzero digit, and by doing the same with reset. It expects zero and all ones to appear on the next edge, with the digit having no effect. A related collision is a digit presented while only one of valid and enable is high. After such a stall cycle the bench confirms that both outputs are unchanged, and then that the stream resumes with the correct value.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_PLUS = 2'b01,
        DIG_MINUS = 2'b10
    } sd_digit_e;

    typedef struct packed {
        logic plus;
        logic minus;
    } bs_pair_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'b00,
        ACT_CLEAR = 2'b01,
        ACT_SHIFT = 2'b10
    } reg_action_e;

    function automatic sd_digit_e bs_decode(input bs_pair_t p);
        sd_digit_e d;
        case ({p.plus, p.minus})
            2'b10:   d = DIG_PLUS;
            2'b01:   d = DIG_MINUS;
            default: d = DIG_ZERO;
        endcase
        return d;
    endfunction

    function automatic reg_action_e pick_action(input logic rst,
                                                input logic clr,
                                                input logic take);
        reg_action_e a;
        if (rst || clr)
            a = ACT_CLEAR;
        else if (take)
            a = ACT_SHIFT;
        else
            a = ACT_HOLD;
        return a;
    endfunction

endpackage

// File: rtl/sdc_digit_decode.sv
module sdc_digit_decode
    import sdc_pkg::*;
(
    input  logic        rst,
    input  logic        clr,
    input  logic        vld,
    input  logic        en,
    input  bs_pair_t    pair,
    output sd_digit_e   digit,
    output reg_action_e action
);

    always_comb begin
        digit  = bs_decode(pair);
        action = pick_action(rst, clr, vld && en);
    end

endmodule

// File: rtl/sdc_append_reg.sv
module sdc_append_reg
    import sdc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  reg_action_e    action,
    input  sd_digit_e      digit,
    output logic [W-1:0]   q,
    output logic [W-1:0]   qm
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] ZERO     = '0;

    logic [W-1:0] q_nxt;
    logic [W-1:0] qm_nxt;
    logic [W-2:0] q_low;
    logic [W-2:0] qm_low;

    assign q_low  = q[W-2:0];
    assign qm_low = qm[W-2:0];

    always_comb begin
        q_nxt  = q;
        qm_nxt = qm;
        unique case (action)
            ACT_CLEAR: begin
                q_nxt  = ZERO;
                qm_nxt = ALL_ONES;
            end
            ACT_SHIFT: begin
                unique case (digit)
                    DIG_PLUS: begin
                        q_nxt  = {q_low, 1'b1};
                        qm_nxt = {q_low, 1'b0};
                    end
                    DIG_MINUS: begin
                        q_nxt  = {qm_low, 1'b1};
                        qm_nxt = {qm_low, 1'b0};
                    end
                    default: begin
                        q_nxt  = {q_low, 1'b0};
                        qm_nxt = {qm_low, 1'b1};
                    end
                endcase
            end
            default: begin
                q_nxt  = q;
                qm_nxt = qm;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        q  <= q_nxt;
        qm <= qm_nxt;
    end

endmodule

// File: rtl/sdc_result_sel.sv
module sdc_result_sel #(
    parameter int W = 8
) (
    input  logic           use_dec,
    input  logic [W-1:0]   val,
    input  logic [W-1:0]   val_dec,
    output logic [W-1:0]   result
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign result[i] = use_dec ? val_dec[i] : val[i];
    end

endmodule

// File: rtl/sdc_onthefly_conv.sv
module sdc_onthefly_conv
    import sdc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_i,
    input  logic           dig_vld_i,
    input  logic           shift_en_i,
    input  logic           dig_pos_i,
    input  logic           dig_neg_i,
    input  logic           neg_rem_i,
    output logic [W-1:0]   q_o,
    output logic [W-1:0]   qm_o,
    output logic [W-1:0]   root_o
);

    bs_pair_t    pair;
    sd_digit_e   digit;
    reg_action_e action;

    assign pair.plus  = dig_pos_i;
    assign pair.minus = dig_neg_i;

    sdc_digit_decode u_dec (
        .rst    (rst),
        .clr    (clr_i),
        .vld    (dig_vld_i),
        .en     (shift_en_i),
        .pair   (pair),
        .digit  (digit),
        .action (action)
    );

    sdc_append_reg #(.W(W)) u_regs (
        .clk    (clk),
        .action (action),
        .digit  (digit),
        .q      (q_o),
        .qm     (qm_o)
    );

    sdc_result_sel #(.W(W)) u_sel (
        .use_dec (neg_rem_i),
        .val     (q_o),
        .val_dec (qm_o),
        .result  (root_o)
    );

endmodule

// File: rtl/sdc_onthefly_conv_chk.sv
module sdc_onthefly_conv_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           clr_i,
    input logic           dig_vld_i,
    input logic           shift_en_i,
    input logic           dig_pos_i,
    input logic           dig_neg_i,
    input logic           neg_rem_i,
    input logic [W-1:0]   q_o,
    input logic [W-1:0]   qm_o,
    input logic [W-1:0]   root_o
);

    localparam logic [W-1:0] ONE = 1;

    logic take;
    assign take = dig_vld_i && shift_en_i && !clr_i;

    // R4
    a_r4_dec_tracks: assert property (@(posedge clk) disable iff (rst)
        qm_o == q_o - ONE);

    // R5
    a_r5_clear_state: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (q_o == '0) && (qm_o == '1));

    // R6
    a_r6_reset_state: assert property (@(posedge clk)
        rst |=> (q_o == '0) && (qm_o == '1));

    // R2
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !(dig_vld_i && shift_en_i)) |=> ($stable(q_o) && $stable(qm_o)));

    // R1, R3
    a_r3_plus: assert property (@(posedge clk) disable iff (rst)
        (take && dig_pos_i && !dig_neg_i) |=> q_o == (($past(q_o) << 1) + ONE));

    a_r3_minus: assert property (@(posedge clk) disable iff (rst)
        (take && !dig_pos_i && dig_neg_i) |=> q_o == (($past(q_o) << 1) - ONE));

    a_r1_zero: assert property (@(posedge clk) disable iff (rst)
        (take && (dig_pos_i == dig_neg_i)) |=> q_o == ($past(q_o) << 1));

    // R7
    a_r7_select: assert property (@(posedge clk) disable iff (rst)
        root_o == (neg_rem_i ? qm_o : q_o));

endmodule

bind sdc_onthefly_conv sdc_onthefly_conv_chk #(.W(W)) u_chk (.*);

// File: tb/test_sdc_onthefly_conv.sv
module test_sdc_onthefly_conv;

    localparam int W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, clr_i, dig_vld_i, shift_en_i, dig_pos_i, dig_neg_i, neg_rem_i;
    logic [W-1:0] q_o, qm_o, root_o;

    sdc_onthefly_conv #(.W(W)) i_sdc_onthefly_conv (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr_i),
        .dig_vld_i  (dig_vld_i),
        .shift_en_i (shift_en_i),
        .dig_pos_i  (dig_pos_i),
        .dig_neg_i  (dig_neg_i),
        .neg_rem_i  (neg_rem_i),
        .q_o        (q_o),
        .qm_o       (qm_o),
        .root_o     (root_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [W-1:0] mq;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, model, check at following negedge
    task automatic cycle(input bit r, input bit c, input bit v, input bit e,
                         input int d, input bit zero_hi, input string req);
        rst = r; clr_i = c; dig_vld_i = v; shift_en_i = e;
        dig_pos_i = (d == 1) || (d == 0 && zero_hi);
        dig_neg_i = (d == -1) || (d == 0 && zero_hi);
        if (r || c)
            mq = '0;
        else if (v && e)
            mq = W'((int'(mq) * 2) + d);
        @(negedge clk);
        chk(req, q_o, mq);
        chk("R4", qm_o, mq - W'(1));
    endtask

    task automatic check_sel();
        neg_rem_i = 1'b1; #1;
        chk("R7 neg", root_o, mq - W'(1));
        neg_rem_i = 1'b0; #1;
        chk("R7 pos", root_o, mq);
    endtask

    initial begin
        rst = 1'b1; clr_i = 1'b0; dig_vld_i = 1'b0; shift_en_i = 1'b0;
        dig_pos_i = 1'b0; dig_neg_i = 1'b0; neg_rem_i = 1'b0;
        mq = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 reset q", q_o, '0);
        chk("R6 reset qm", qm_o, '1);

        // all 5-digit sequences over {0,+1,-1}, stalls mixed in
        for (int s = 0; s < 243; s++) begin
            int rem;
            rem = s;
            cycle(0, 1, 0, 0, 0, 0, "R5 clear");
            for (int k = 0; k < 5; k++) begin
                int dg;
                dg = rem % 3;
                rem = rem / 3;
                if (dg == 2) dg = -1;
                if (k == 2) cycle(0, 0, 1, 0, 1, 0, "R2 stall no enable");
                if (k == 3) cycle(0, 0, 0, 1, -1, 0, "R2 stall no valid");
                cycle(0, 0, 1, 1, dg, ((s + k) % 2) == 1, "R3 R1 digit");
            end
            if (s % 16 == 0) check_sel();
        end

        // clear against an accepted digit
        cycle(0, 0, 1, 1, 1, 0, "R3 setup");
        cycle(0, 1, 1, 1, 1, 0, "R5 clear beats digit");
        cycle(0, 0, 1, 1, -1, 0, "R3 after clear");
        cycle(1, 0, 1, 1, 1, 0, "R6 reset beats digit");

        // long streams wrap modulo 2^W
        cycle(0, 1, 0, 0, 0, 0, "R5 clear");
        for (int k = 0; k < 12; k++) cycle(0, 0, 1, 1, 1, 0, "R3 wrap plus");
        check_sel();
        cycle(0, 1, 0, 0, 0, 0, "R5 clear");
        for (int k = 0; k < 11; k++) cycle(0, 0, 1, 1, -1, k[0], "R3 wrap minus");
        check_sel();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule